// File: doc/BRIEF.md
# External DMA Request Handshake Synchronizer

This block takes an active-low DMA request line driven by an external peripheral, with no timing relation to the bus clock, and turns it into burst transactions in the bus clock domain. The line passes through a chain of flip-flops. A transaction starts only on the clock after the synchronized line goes from released to asserted. A line that simply stays asserted never starts a transaction.

When a transaction starts, the block latches a burst length chosen by a 2-bit code. It then counts per-beat completion strobes from the bus master. The block marks the final beat and returns a one-cycle acknowledge to the requester when the burst ends. The requester must release its line after the last transfer and assert it again before the next transaction. An assertion that arrives while a burst is running is dropped and is not queued. A line held low through reset is not treated as a request until it has been released and asserted again.

Top module: `eds_req_sync`

## Requirements
- R1: While reset is high and on the first cycle after it, `txn_start`, `txn_busy`, `last_beat` and `dma_ack` are 0 and `txn_len` is 0.
- R2: If `req_n` is low through reset, no transaction starts until `req_n` has been seen high and then low again.
- R3: When `req_n` falls and the first rising clock edge samples it low, `txn_start` goes high after the third rising edge, counting that one. It is low after the first and second edges.
- R4: The burst length is latched into `txn_len` when a transaction starts. The code map is: 0 gives 1 beat, 1 gives 4, 2 gives 8 and 3 gives 16. A change of `burst_code` during a transaction does not change `txn_len` or the number of beats.
- R5: `last_beat` is high while `txn_busy` is high and exactly one beat remains. Otherwise it is low.
- R6: The rising edge that takes the final `beat_done` drops `txn_busy` and raises `dma_ack` for exactly one cycle.
- R7: A request edge that arrives while a transaction is busy is ignored and is not queued. This includes an edge in the same cycle as the final beat.
- R8: If `req_n` stays low after a transaction ends, no further transaction starts.
- R9: A `beat_done` strobe while idle has no effect: no acknowledge and no busy.
- R10: `txn_start` is a one-cycle pulse, and `txn_busy` is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| req_n | input | 1 | Asynchronous DMA request line from the peripheral, active low |
| burst_code | input | 2 | Burst length select: 0→1, 1→4, 2→8, 3→16 beats |
| beat_done | input | 1 | Bus master strobe, one per completed data beat |
| txn_start | output | 1 | One-cycle pulse when a transaction begins |
| txn_busy | output | 1 | High while a transaction is in progress |
| last_beat | output | 1 | High while the next beat is the final one |
| txn_len | output | 5 | Beat count latched at the start of the current or most recent transaction |
| dma_ack | output | 1 | One-cycle acknowledge after the final beat |

## Verification
The risky overlap is a new request edge and the final beat of the running burst landing in the same cycle. The edge must lose, because the block is still busy on that edge. The bench provokes this by releasing the line during a burst, then asserting it again so that the synchronized edge lines up with the last `beat_done`. It judges the result by seeing `dma_ack` with no `txn_start`, and no start in the cycles that follow while the line stays low.

// File: rtl/eds_pkg.sv
package eds_pkg;
  localparam int LEN_W = 5;

  typedef enum logic [1:0] {
    BURST_1  = 2'd0,
    BURST_4  = 2'd1,
    BURST_8  = 2'd2,
    BURST_16 = 2'd3
  } burst_code_e;

  function automatic logic [LEN_W-1:0] burst_len(input logic [1:0] code);
    logic [LEN_W-1:0] n;
    case (burst_code_e'(code))
      BURST_1:  n = LEN_W'(1);
      BURST_4:  n = LEN_W'(4);
      BURST_8:  n = LEN_W'(8);
      default:  n = LEN_W'(16);
    endcase
    return n;
  endfunction
endpackage

// File: rtl/eds_sync.sv
module eds_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_VAL;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/eds_edge.sv
module eds_edge (
  input  logic clk,
  input  logic rst,
  input  logic pin_s,
  output logic rise
);
  // Holds the synchronized pin one cycle back. Cleared at reset, which reads as
  // "line asserted", so a line held low through reset gives no edge.
  logic pin_d;

  always_ff @(posedge clk) begin
    if (rst) pin_d <= 1'b0;
    else     pin_d <= pin_s;
  end

  // The internal request is active high, so its rising edge is a high-to-low
  // step of the synchronized pin.
  assign rise = pin_d & ~pin_s;
endmodule

// File: rtl/eds_burst_seq.sv
module eds_burst_seq
  import eds_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rise,
  input  logic [1:0]       code,
  input  logic             beat_done,
  output logic             txn_start,
  output logic             busy,
  output logic             last,
  output logic             ack,
  output logic [LEN_W-1:0] len
);
  logic [LEN_W-1:0] remaining;
  logic [LEN_W-1:0] new_len;

  assign new_len = burst_len(code);

  always_ff @(posedge clk) begin
    if (rst) begin
      txn_start <= 1'b0;
      busy      <= 1'b0;
      last      <= 1'b0;
      ack       <= 1'b0;
      len       <= '0;
      remaining <= '0;
    end else begin
      txn_start <= 1'b0;
      ack       <= 1'b0;
      if (!busy) begin
        if (rise) begin
          busy      <= 1'b1;
          txn_start <= 1'b1;
          len       <= new_len;
          remaining <= new_len;
          last      <= (new_len == LEN_W'(1));
        end
      end else if (beat_done) begin
        if (last) begin
          busy      <= 1'b0;
          last      <= 1'b0;
          ack       <= 1'b1;
          remaining <= '0;
        end else begin
          remaining <= remaining - LEN_W'(1);
          last      <= (remaining == LEN_W'(2));
        end
      end
    end
  end
endmodule

// File: rtl/eds_req_sync.sv
module eds_req_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_n,
  input  logic [1:0]              burst_code,
  input  logic                    beat_done,
  output logic                    txn_start,
  output logic                    txn_busy,
  output logic                    last_beat,
  output logic [eds_pkg::LEN_W-1:0] txn_len,
  output logic                    dma_ack
);
  logic pin_s;
  logic rise_w;

  eds_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (req_n),
    .q   (pin_s)
  );

  eds_edge u_edge (
    .clk   (clk),
    .rst   (rst),
    .pin_s (pin_s),
    .rise  (rise_w)
  );

  eds_burst_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .rise      (rise_w),
    .code      (burst_code),
    .beat_done (beat_done),
    .txn_start (txn_start),
    .busy      (txn_busy),
    .last      (last_beat),
    .ack       (dma_ack),
    .len       (txn_len)
  );
endmodule

// File: rtl/eds_req_sync_chk.sv
module eds_req_sync_chk (
  input logic       clk,
  input logic       rst,
  input logic       rise,
  input logic       beat_done,
  input logic       txn_start,
  input logic       txn_busy,
  input logic       last_beat,
  input logic [4:0] txn_len,
  input logic       dma_ack
);
  a_r10_start_pulse: assert property (@(posedge clk) disable iff (rst)
    txn_start |=> !txn_start);

  a_r10_start_busy: assert property (@(posedge clk) disable iff (rst)
    txn_start |-> txn_busy);

  a_r7_start_from_idle_edge: assert property (@(posedge clk) disable iff (rst)
    txn_start |-> $past(rise && !txn_busy));

  a_r5_last_only_busy: assert property (@(posedge clk) disable iff (rst)
    last_beat |-> txn_busy);

  a_r6_ack_pulse: assert property (@(posedge clk) disable iff (rst)
    dma_ack |=> !dma_ack);

  a_r6_ack_after_last: assert property (@(posedge clk) disable iff (rst)
    dma_ack |-> ($past(last_beat && beat_done && txn_busy) && !txn_busy));

  a_r4_len_stable: assert property (@(posedge clk) disable iff (rst)
    (txn_busy && !txn_start) |-> $stable(txn_len));

  a_r9_idle_no_ack: assert property (@(posedge clk) disable iff (rst)
    (!txn_busy && beat_done) |=> !dma_ack);
endmodule

bind eds_req_sync eds_req_sync_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .rise      (rise_w),
  .beat_done (beat_done),
  .txn_start (txn_start),
  .txn_busy  (txn_busy),
  .last_beat (last_beat),
  .txn_len   (txn_len),
  .dma_ack   (dma_ack)
);

// File: tb/eds_req_sync_tb_top.sv
`timescale 1ns/1ps
module eds_req_sync_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst, req_n, beat_done;
  logic [1:0] burst_code;
  logic       txn_start, txn_busy, last_beat, dma_ack;
  logic [4:0] txn_len;

  int checks = 0, errors = 0, starts = 0;
  bit done = 0;

  eds_req_sync dut_i (
    .clk(clk), .rst(rst), .req_n(req_n), .burst_code(burst_code),
    .beat_done(beat_done), .txn_start(txn_start), .txn_busy(txn_busy),
    .last_beat(last_beat), .txn_len(txn_len), .dma_ack(dma_ack)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
    if (txn_start) starts++;
  endtask

  function automatic int len_of(input int c);
    return (c == 0) ? 1 : (4 << (c - 1));
  endfunction

  // Falls req_n and checks R3 timing and R4 latching; ends in the start cycle.
  task automatic start_txn(input int c);
    burst_code = 2'(c);
    req_n = 1'b0;
    tick; chk(!txn_start, "R3 early1", int'(txn_start), 0);
    tick; chk(!txn_start, "R3 early2", int'(txn_start), 0);
    tick; chk(txn_start && txn_busy, "R3/R10 start", int'(txn_start), 1);
    chk(txn_len == 5'(len_of(c)), "R4 len", int'(txn_len), len_of(c));
  endtask

  task automatic beats(input int first, input int count, input int len, input int gap);
    for (int i = first; i < first + count; i++) begin
      chk(last_beat == (i == len - 1), "R5 last", int'(last_beat), int'(i == len - 1));
      beat_done = 1'b1;
      tick;
      beat_done = 1'b0;
      if (i == len - 1) begin
        chk(dma_ack && !txn_busy, "R6 ack", int'(dma_ack), 1);
        tick;
        chk(!dma_ack, "R6 one cycle", int'(dma_ack), 0);
      end else begin
        chk(!dma_ack && txn_busy, "R6 no early ack", int'(dma_ack), 0);
        repeat (gap) tick;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req_n = 1'b0; beat_done = 1'b0; burst_code = 2'd0;
    repeat (3) tick;
    chk(!txn_start && !txn_busy && !last_beat && !dma_ack && txn_len == 0,
        "R1 in reset", int'(txn_busy), 0);
    rst = 1'b0;
    tick;
    chk(!txn_start && !txn_busy && !last_beat && !dma_ack && txn_len == 0,
        "R1 after reset", int'(txn_busy), 0);
    repeat (10) tick;
    chk(starts == 0, "R2 held low at reset", starts, 0);
    req_n = 1'b1; repeat (4) tick;

    // Sweep all codes and beat gaps; gap 1 also changes the code mid-burst.
    for (int c = 0; c < 4; c++) begin
      for (int g = 0; g < 3; g++) begin
        start_txn(c);
        if (g == 1) burst_code = ~2'(c);
        tick;
        chk(!txn_start, "R10 pulse", int'(txn_start), 0);
        beats(0, len_of(c), len_of(c), g);
        chk(txn_len == 5'(len_of(c)), "R4 code change", int'(txn_len), len_of(c));
        req_n = 1'b1; repeat (4) tick;
      end
    end

    // R8: line stays low after the burst
    begin
      int s0;
      start_txn(1); tick;
      beats(0, 4, 4, 0);
      s0 = starts;
      repeat (12) tick;
      chk(starts == s0, "R8 held low", starts - s0, 0);
      req_n = 1'b1; repeat (4) tick;
    end

    // R7: release and reassert in the middle of a 16-beat burst
    begin
      int s0;
      start_txn(3); tick;
      beats(0, 5, 16, 0);
      s0 = starts;
      req_n = 1'b1; repeat (3) tick;
      req_n = 1'b0; repeat (3) tick;
      beats(5, 11, 16, 1);
      repeat (10) tick;
      chk(starts == s0 && !txn_busy, "R7 mid-burst edge", starts - s0, 0);
      req_n = 1'b1; repeat (4) tick;
    end

    // R7: edge in the same cycle as the final beat
    begin
      int s0;
      start_txn(1); tick;
      beats(0, 3, 4, 0);
      req_n = 1'b1; repeat (3) tick;
      s0 = starts;
      req_n = 1'b0; tick; tick;
      chk(last_beat, "R5 before coincident", int'(last_beat), 1);
      beat_done = 1'b1; tick; beat_done = 1'b0;
      chk(dma_ack && !txn_start, "R7 coincident", int'(txn_start), 0);
      repeat (10) tick;
      chk(starts == s0 && !txn_busy, "R7 not queued", starts - s0, 0);
      req_n = 1'b1; repeat (4) tick;
    end

    // R9: beat strobe while idle
    beat_done = 1'b1; tick; beat_done = 1'b0;
    chk(!dma_ack && !txn_busy, "R9 idle beat", int'(dma_ack), 0);
    tick;
    chk(!dma_ack && !txn_busy, "R9 idle after", int'(txn_busy), 0);

    // Fresh request still works afterwards
    start_txn(0); tick;
    beats(0, 1, 1, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule